// File: doc/BRIEF.md
# Bus hold handshake controller

This block lets an outside master borrow the memory-interface bus. The master pulls an active-low hold request. The controller first lets the local side finish any transfer it has already started, including a transfer stretched by a ready input or a whole burst. It then floats every interface pin through one shared output-enable and answers with an active-low acknowledge. When the request goes away, the bus is driven again before the acknowledge is withdrawn. A veto input keeps the bus local for as long as it is set.

The request input may be fully asynchronous, so it passes through a two-flop synchronizer. All latencies are counted in interface clock cycles from the first rising edge that samples the new level of the request pin. While a handover is in progress or the bus is lent out, a stall output stops the local issuer from starting new transactions. If the request is dropped before the bus has been floated, the handover is abandoned and the bus never leaves local control.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While reset is applied and right after it is released, `holda_n` is 1, `bus_oe` is 1 and `stall` is 0.
- R2: When the local side is idle and `hold_n` is first sampled low at edge k, `bus_oe` goes to 0 at edge k+4 and not earlier.
- R3: `bus_oe` never goes to 0 while `eng_busy` or `burst_active` is sampled high. If either of them is held high through edge k+n-1, the bus floats at edge max(k+4, k+n).
- R4: While `nohold` is 1, a low `hold_n` never makes `bus_oe` go to 0 and never makes `holda_n` go to 0.
- R5: `holda_n` goes to 0 exactly one edge after `bus_oe` goes to 0, and never while the bus is driven.
- R6: When `hold_n` is first sampled high at edge m during a grant, `bus_oe` returns to 1 at edge m+3.
- R7: `holda_n` returns to 1 at edge m+4, and only after the bus has been driven for at least one cycle.
- R8: `stall` rises at edge k+2 of a handover, stays high while the bus is floated or the acknowledge is low, and falls together with the rise of `holda_n`.
- R9: If `hold_n` returns high while the controller is still waiting for local work to finish, the handover is abandoned: `bus_oe` and `holda_n` stay 1 and `stall` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 1 | Asynchronous active-low bus request from the outside master |
| nohold | input | 1 | Veto: 1 refuses every bus request |
| eng_busy | input | 1 | Local bus engine has a transaction in flight |
| burst_active | input | 1 | Local multi-beat burst in progress |
| bus_oe | output | 1 | 1 drives all interface pins, 0 floats them |
| holda_n | output | 1 | Active-low acknowledge to the outside master |
| stall | output | 1 | Blocks new local transactions while high |

## Verification
The float is due on edge k+4, or on the first edge after the last busy edge if that is later. The acknowledge follows one edge after the float. On release the bus is driven again on edge m+3 and the acknowledge rises on edge m+4, with stall rising at k+2 and falling at m+4. The bench changes every input on the falling clock edge, so the edge that samples a change is known exactly. It then counts the falling edges that follow, records the first one at which each output has changed, and compares that count with these formulas. The count of busy edges is swept from zero to nine for both busy sources, and the hold length and idle gaps are random.

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DRAIN_MIN   = 2,
  parameter int REDRIVE_GAP = 1,
  parameter int RELEASE_GAP = 2,
  parameter int CNT_W       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_n,
  input  logic nohold,
  input  logic eng_busy,
  input  logic burst_active,
  output logic bus_oe,
  output logic holda_n,
  output logic stall
);

  typedef enum logic [2:0] {S_OWN, S_DRAIN, S_TRISTATE, S_GRANTED, S_RECLAIM} state_t;

  localparam logic [CNT_W-1:0] DRAIN_LAST   = CNT_W'(DRAIN_MIN - 1);
  localparam logic [CNT_W-1:0] RELEASE_LAST = CNT_W'(RELEASE_GAP - 1);
  localparam logic [CNT_W-1:0] REDRIVE_AT   = CNT_W'(REDRIVE_GAP);
  localparam logic [CNT_W-1:0] CNT_MAX      = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] sync_q;
  state_t state, state_nx;
  logic [CNT_W-1:0] cnt;

  wire hold_req = ~sync_q[SYNC_STAGES-1];
  wire idle     = ~eng_busy & ~burst_active;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], hold_n};

  always_comb begin
    state_nx = state;
    case (state)
      S_OWN:      if (hold_req && !nohold) state_nx = S_DRAIN;
      S_DRAIN:    if (!hold_req || nohold) state_nx = S_OWN;
                  else if (cnt >= DRAIN_LAST && idle) state_nx = S_TRISTATE;
      S_TRISTATE: state_nx = S_GRANTED;
      S_GRANTED:  if (!hold_req) state_nx = S_RECLAIM;
      S_RECLAIM:  if (cnt >= RELEASE_LAST) state_nx = S_OWN;
      default:    state_nx = S_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_OWN;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      if (state_nx != state) cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

  assign bus_oe  = ~((state == S_TRISTATE) || (state == S_GRANTED) ||
                     ((state == S_RECLAIM) && (cnt < REDRIVE_AT)));
  assign holda_n = ~((state == S_GRANTED) || (state == S_RECLAIM));
  assign stall   = (state != S_OWN);

  p_wait_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> $past(~eng_busy & ~burst_active));

  p_veto_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nohold && holda_n && bus_oe) |=> bus_oe);

  p_grant_follows_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |=> $fell(holda_n));

  p_no_grant_while_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holda_n) |-> !bus_oe);

  p_release_after_redrive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holda_n) |-> (bus_oe && $past(bus_oe)));

  p_stall_while_lent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe || !holda_n) |-> stall);

endmodule

// File: tb/bus_hold_ctrl_tb.sv
`timescale 1ns/1ps
module bus_hold_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_n = 1'b1, nohold = 1'b0, eng_busy = 1'b0, burst_active = 1'b0;
  logic bus_oe, holda_n, stall;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_hold_ctrl dut_i (.clk(clk), .rst_n(rst_n), .hold_n(hold_n), .nohold(nohold),
    .eng_busy(eng_busy), .burst_active(burst_active),
    .bus_oe(bus_oe), .holda_n(holda_n), .stall(stall));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic grant(input int nb, input bit use_burst);
    int t_off, t_ack, t_on, t_rel, t_unstall, hold_len, e;
    t_off = -1; t_ack = -1; t_on = -1; t_rel = -1; t_unstall = -1;
    hold_len = 20 + int'($urandom_range(0, 6));
    @(negedge clk);
    hold_n = 1'b0;
    if (nb > 0) begin
      if (use_burst) burst_active = 1'b1; else eng_busy = 1'b1;
    end
    for (int j = 0; j < hold_len; j++) begin
      @(negedge clk);
      if (t_off < 0 && !bus_oe) t_off = j;
      if (t_ack < 0 && !holda_n) t_ack = j;
      if (j == 1) chk(stall == 1'b0, "R8 stall before k+2", int'(stall), 0);
      if (j == 2) chk(stall == 1'b1, "R8 stall at k+2", int'(stall), 1);
      if (j == nb - 1) begin eng_busy = 1'b0; burst_active = 1'b0; end
    end
    e = (nb > 4) ? nb : 4;
    chk(t_off == e, (nb > 0) ? "R3 float edge after busy" : "R2 float edge idle", t_off, e);
    chk(t_ack == t_off + 1, "R5 ack one edge after float", t_ack, t_off + 1);
    hold_n = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (t_on < 0 && bus_oe) t_on = j;
      if (t_rel < 0 && holda_n) t_rel = j;
      if (t_unstall < 0 && !stall) t_unstall = j;
    end
    chk(t_on == 3, "R6 redrive edge", t_on, 3);
    chk(t_rel == 4, "R7 ack release edge", t_rel, 4);
    chk(t_unstall == 4, "R8 stall release edge", t_unstall, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(holda_n == 1'b1 && bus_oe == 1'b1 && stall == 1'b0, "R1 in reset",
        {29'd0, holda_n, bus_oe, stall}, 6);
    rst_n = 1'b1;
    idle_gap(2);
    chk(holda_n == 1'b1 && bus_oe == 1'b1 && stall == 1'b0, "R1 after reset",
        {29'd0, holda_n, bus_oe, stall}, 6);

    for (int nb = 0; nb < 10; nb++)
      for (int b = 0; b < 2; b++) begin
        grant(nb, b[0]);
        idle_gap(1 + int'($urandom_range(0, 4)));
      end

    nohold = 1'b1;
    @(negedge clk);
    hold_n = 1'b0;
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);
      chk(bus_oe == 1'b1 && holda_n == 1'b1, "R4 veto keeps bus",
          {30'd0, bus_oe, holda_n}, 3);
    end
    hold_n = 1'b1;
    idle_gap(4);
    nohold = 1'b0;
    idle_gap(2);

    @(negedge clk);
    hold_n = 1'b0;
    eng_busy = 1'b1;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      if (j == 2) hold_n = 1'b1;
      if (j == 3) chk(stall == 1'b1, "R9 stall during drain", int'(stall), 1);
      chk(bus_oe == 1'b1 && holda_n == 1'b1, "R9 abort keeps bus",
          {30'd0, bus_oe, holda_n}, 3);
    end
    chk(stall == 1'b0, "R9 stall cleared after abort", int'(stall), 0);
    eng_busy = 1'b0;
    idle_gap(3);
    grant(0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1-flow actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule